// File: doc/BRIEF.md
# Card Socket Window Decoder

This block decodes host addresses for a 16-bit PC Card host controller that has two card slots. It holds eight address windows. Each window has a base register and an option register, and both are reached through a small write/read configuration port. On every cycle the block compares the host address against all enabled windows and reports which of them match. It also reports the winning window and the attributes of that window: the target slot, the region type, the port width, the write-protect state and three access timing counts. The block also produces a card-side address. There is no separate offset register, so the card address is always the distance from the window's size-aligned base.

A downstream bus sequencer uses these outputs to drive the card strobes. The decoder itself raises an access-grant signal, or a protection-violation pulse when a write targets a write-protected window. It also flags any window whose programmed timing would reach the bus-monitor limit.

Top module: `pcs_window_decoder`

## Requirements
- R1: There are 8 windows. Configuration index 2n holds the base of window n and index 2n+1 holds its option word. A write is visible on `cfg_rdata` from the next cycle, and reset clears all sixteen registers to zero.
- R2: Option bit 0 enables the window. A window with this bit clear never hits, so writing zero to its option word disables it.
- R3: On a hit the outputs carry fields of the winning window's option word: `wprot` from bit 1, `slot` from bit 2 (0 = first slot, 1 = second), `region` from bits 4:3 (00 common memory, 10 attribute memory, 11 I/O) and `wide16` from bit 6.
- R4: Option bits 31:27 hold the window size code. Codes 0–15 give 1, 2, 8, 4, 128, 64, 16, 32, 32K, 16K, 4K, 8K, 256, 512, 2K and 1K bytes. Codes 24–31 give 64K, 128K, 512K, 256K, 8M, 4M, 1M and 2M bytes. Code 20 gives 16M, code 21 gives 32M and code 23 gives 64M.
- R5: Size codes 16, 17, 18, 19 and 22 are reserved. A window that uses one of them never hits.
- R6: A window hits when the host address and its base agree on every bit at or above log2(size). `hit_vec` shows every hitting window. When several windows hit, the lowest-numbered one wins and is reported on `hit_win`.
- R7: On a hit, `card_addr` equals the host address minus the winning base with its low log2(size) bits cleared.
- R8: On a hit, `t_setup` comes from option bits 15:12, `t_strobe` from bits 11:7 and `t_hold` from bits 19:16.
- R9: A valid host write that hits a window with the write-protect bit set raises `prot_err` for that cycle and holds `grant` low. Any other valid hitting access raises `grant`.
- R10: `timing_over[n]` is high exactly when setup + strobe + hold of window n is at least 60 clocks.
- R11: When no window hits, `hit`, `grant`, `prot_err`, `hit_win`, `card_addr` and all attribute and timing outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Register index (2n base, 2n+1 option) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Contents of the indexed register |
| host_valid | input | 1 | Host access present |
| host_write | input | 1 | Host access is a write |
| host_addr | input | 32 | Host address |
| hit | output | 1 | Some window matches |
| hit_win | output | 3 | Winning window number |
| hit_vec | output | 8 | All matching windows |
| slot | output | 1 | Slot of winning window |
| region | output | 2 | Region type of winning window |
| wide16 | output | 1 | 16-bit card port |
| wprot | output | 1 | Write-protect of winning window |
| t_setup | output | 4 | Setup clocks |
| t_strobe | output | 5 | Strobe length clocks |
| t_hold | output | 4 | Hold clocks |
| card_addr | output | 32 | Card-side address |
| grant | output | 1 | Access allowed |
| prot_err | output | 1 | Write to protected window |
| timing_over | output | 8 | Per-window timing sum at or over limit |

## Verification
The assertions check four things on every cycle. The reported winner must itself hit, and no lower-numbered window may hit. A hit must come from an enabled window. Grant and protection violation must never be high together, and a violation needs a protected write. A miss must leave every output quiet. Configuration writes are checked to land in the addressed register. Other behaviour only the directed scenarios can show. These are the scrambled size-code order and the exact edges of every size, the reserved codes, the card-address arithmetic for a base that is not aligned, the field extraction, and the exact sum at which the timing-limit flag switches.

// File: rtl/pcs_window_decoder.sv
module pcs_window_decoder #(
  parameter int NWIN      = 8,
  parameter int AW        = 32,
  parameter int BUS_LIMIT = 60
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(2*NWIN)-1:0]   cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  output logic [31:0]                 cfg_rdata,
  input  logic                        host_valid,
  input  logic                        host_write,
  input  logic [AW-1:0]               host_addr,
  output logic                        hit,
  output logic [$clog2(NWIN)-1:0]     hit_win,
  output logic [NWIN-1:0]             hit_vec,
  output logic                        slot,
  output logic [1:0]                  region,
  output logic                        wide16,
  output logic                        wprot,
  output logic [3:0]                  t_setup,
  output logic [4:0]                  t_strobe,
  output logic [3:0]                  t_hold,
  output logic [AW-1:0]               card_addr,
  output logic                        grant,
  output logic                        prot_err,
  output logic [NWIN-1:0]             timing_over
);
  localparam int IW = $clog2(NWIN);
  localparam int RW = $clog2(2*NWIN);

  logic [31:0]   base_q [NWIN];
  logic [31:0]   opt_q  [NWIN];
  logic [AW-1:0] lo_mask [NWIN];
  logic [IW-1:0] cfg_idx;

  assign cfg_idx = cfg_addr[RW-1:1];

  function automatic logic [5:0] size_lg(input logic [4:0] code);
    case (code)
      5'd0:  size_lg = {1'b1, 5'd0};
      5'd1:  size_lg = {1'b1, 5'd1};
      5'd2:  size_lg = {1'b1, 5'd3};
      5'd3:  size_lg = {1'b1, 5'd2};
      5'd4:  size_lg = {1'b1, 5'd7};
      5'd5:  size_lg = {1'b1, 5'd6};
      5'd6:  size_lg = {1'b1, 5'd4};
      5'd7:  size_lg = {1'b1, 5'd5};
      5'd8:  size_lg = {1'b1, 5'd15};
      5'd9:  size_lg = {1'b1, 5'd14};
      5'd10: size_lg = {1'b1, 5'd12};
      5'd11: size_lg = {1'b1, 5'd13};
      5'd12: size_lg = {1'b1, 5'd8};
      5'd13: size_lg = {1'b1, 5'd9};
      5'd14: size_lg = {1'b1, 5'd11};
      5'd15: size_lg = {1'b1, 5'd10};
      5'd20: size_lg = {1'b1, 5'd24};
      5'd21: size_lg = {1'b1, 5'd25};
      5'd23: size_lg = {1'b1, 5'd26};
      5'd24: size_lg = {1'b1, 5'd16};
      5'd25: size_lg = {1'b1, 5'd17};
      5'd26: size_lg = {1'b1, 5'd19};
      5'd27: size_lg = {1'b1, 5'd18};
      5'd28: size_lg = {1'b1, 5'd23};
      5'd29: size_lg = {1'b1, 5'd22};
      5'd30: size_lg = {1'b1, 5'd20};
      5'd31: size_lg = {1'b1, 5'd21};
      default: size_lg = 6'd0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        opt_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr[0]) opt_q[cfg_idx]  <= cfg_wdata;
      else             base_q[cfg_idx] <= cfg_wdata;
    end
  end

  assign cfg_rdata = cfg_addr[0] ? opt_q[cfg_idx] : base_q[cfg_idx];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [5:0]    sz;
    logic [AW-1:0] hi_mask;
    logic [6:0]    tsum;
    logic          unused_bits;
    assign sz          = size_lg(opt_q[g][31:27]);
    assign hi_mask     = {AW{1'b1}} << sz[4:0];
    assign lo_mask[g]  = ~hi_mask;
    assign hit_vec[g]  = opt_q[g][0] & sz[5] &
                         ~|((host_addr ^ base_q[g][AW-1:0]) & hi_mask);
    assign tsum        = 7'(opt_q[g][15:12]) + 7'(opt_q[g][11:7]) + 7'(opt_q[g][19:16]);
    assign timing_over[g] = tsum >= 7'(BUS_LIMIT);
    assign unused_bits = ^{opt_q[g][26:20], opt_q[g][5]};
  end

  always_comb begin
    hit_win = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit_vec[i]) hit_win = IW'(i);
  end

  logic [31:0] sel;
  assign hit = |hit_vec;
  assign sel = hit ? opt_q[hit_win] : '0;

  assign wprot    = sel[1];
  assign slot     = sel[2];
  assign region   = sel[4:3];
  assign wide16   = sel[6];
  assign t_strobe = sel[11:7];
  assign t_setup  = sel[15:12];
  assign t_hold   = sel[19:16];

  assign card_addr = hit ? host_addr - (base_q[hit_win][AW-1:0] & ~lo_mask[hit_win]) : '0;
  assign grant     = host_valid & hit & ~(host_write & wprot);
  assign prot_err  = host_valid & hit & host_write & wprot;

  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ($past(cfg_addr[0]) ? opt_q[$past(cfg_idx)] : base_q[$past(cfg_idx)]) == $past(cfg_wdata));
  a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> opt_q[hit_win][0]);
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_vec[hit_win] && ((hit_vec & ((NWIN'(1) << hit_win) - NWIN'(1))) == '0));
  a_r9_grant_excludes_violation: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && prot_err));
  a_r9_violation_cause: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> host_valid && host_write && wprot);
  a_r11_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !grant && !prot_err && card_addr == '0 && t_setup == '0 && t_strobe == '0 && t_hold == '0);
endmodule

// File: tb/sim_pcs_window_decoder.sv
module sim_pcs_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        host_valid = 1'b0;
  logic        host_write = 1'b0;
  logic [31:0] host_addr = '0;
  logic        hit, slot, wide16, wprot, grant, prot_err;
  logic [2:0]  hit_win;
  logic [7:0]  hit_vec, timing_over;
  logic [1:0]  region;
  logic [3:0]  t_setup, t_hold;
  logic [4:0]  t_strobe;
  logic [31:0] card_addr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pcs_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_valid(host_valid),
    .host_write(host_write), .host_addr(host_addr), .hit(hit), .hit_win(hit_win),
    .hit_vec(hit_vec), .slot(slot), .region(region), .wide16(wide16), .wprot(wprot),
    .t_setup(t_setup), .t_strobe(t_strobe), .t_hold(t_hold), .card_addr(card_addr),
    .grant(grant), .prot_err(prot_err), .timing_over(timing_over)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = 4'(idx); cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 16; i++) wr(i, 32'h0);
  endtask

  task automatic access(input logic [31:0] a, input logic w);
    host_addr = a; host_write = w; host_valid = 1'b1;
    #1;
  endtask

  function automatic logic [31:0] mk(input int code, input int su, input int st, input int ho,
                                     input bit w16, input logic [1:0] rg, input bit sl,
                                     input bit wp, input bit v);
    return {5'(code), 7'b0, 4'(ho), 4'(su), 5'(st), w16, 1'b0, rg, sl, wp, v};
  endfunction

  function automatic int exp_size(input int code);
    case (code)
      0: return 1;        1: return 2;        2: return 8;        3: return 4;
      4: return 128;      5: return 64;       6: return 16;       7: return 32;
      8: return 32768;    9: return 16384;    10: return 4096;    11: return 8192;
      12: return 256;     13: return 512;     14: return 2048;    15: return 1024;
      20: return 1 << 24; 21: return 1 << 25; 23: return 1 << 26;
      24: return 1 << 16; 25: return 1 << 17; 26: return 1 << 19; 27: return 1 << 18;
      28: return 1 << 23; 29: return 1 << 22; 30: return 1 << 20; 31: return 1 << 21;
      default: return 0;
    endcase
  endfunction

  task automatic t_reset();
    for (int i = 0; i < 16; i++) begin
      cfg_addr = 4'(i); #1;
      chk("R1 reset register zero", cfg_rdata, 32'h0);
    end
    access(32'h0, 1'b0);
    chk("R2 no hit after reset", {31'b0, hit}, 32'h0);
    chk("R11 no grant on miss", {31'b0, grant}, 32'h0);
  endtask

  task automatic t_regs();
    wr(6, 32'hA5A5_0000);
    wr(7, 32'h1234_5678);
    cfg_addr = 4'd6; #1; chk("R1 base readback", cfg_rdata, 32'hA5A5_0000);
    cfg_addr = 4'd7; #1; chk("R1 option readback", cfg_rdata, 32'h1234_5678);
    cfg_addr = 4'd4; #1; chk("R1 neighbour untouched", cfg_rdata, 32'h0);
    clear_all();
  endtask

  task automatic t_basic();
    wr(0, 32'hE000_0000);
    wr(1, mk(23, 2, 9, 1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
    access(32'hE123_4560, 1'b0);
    chk("R6 hit", {31'b0, hit}, 32'h1);
    chk("R6 hit_win", {29'b0, hit_win}, 32'h0);
    chk("R7 card address", card_addr, 32'h0123_4560);
    chk("R9 read grant", {31'b0, grant}, 32'h1);
    access(32'hE400_0000, 1'b0);
    chk("R4 64M edge miss", {31'b0, hit}, 32'h0);
    wr(1, 32'h0);
    access(32'hE123_4560, 1'b0);
    chk("R2 disabled window", {31'b0, hit}, 32'h0);
    chk("R11 miss card address", card_addr, 32'h0);
    clear_all();
  endtask

  task automatic t_sizes();
    wr(0, 32'h4000_0000);
    for (int c = 0; c < 32; c++) begin
      int sz;
      sz = exp_size(c);
      wr(1, mk(c, 1, 1, 1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
      if (sz == 0) begin
        access(32'h4000_0000, 1'b0);
        chk($sformatf("R5 reserved code %0d", c), {31'b0, hit}, 32'h0);
      end else begin
        access(32'h4000_0000 + 32'(sz) - 1, 1'b0);
        chk($sformatf("R4 code %0d last byte hit", c), {31'b0, hit}, 32'h1);
        chk($sformatf("R7 code %0d card address", c), card_addr, 32'(sz) - 1);
        access(32'h4000_0000 + 32'(sz), 1'b0);
        chk($sformatf("R4 code %0d past end miss", c), {31'b0, hit}, 32'h0);
      end
    end
    clear_all();
  endtask

  task automatic t_priority();
    wr(4, 32'h0800_0000);
    wr(5, mk(12, 1, 2, 3, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1));
    wr(10, 32'h0800_0000);
    wr(11, mk(10, 4, 5, 6, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1));
    access(32'h0800_0040, 1'b0);
    chk("R6 hit_vec both", {24'b0, hit_vec}, 32'h24);
    chk("R6 lowest wins", {29'b0, hit_win}, 32'd2);
    chk("R3 region of winner", {30'b0, region}, 32'd2);
    access(32'h0800_0400, 1'b0);
    chk("R6 only larger window", {29'b0, hit_win}, 32'd5);
    wr(5, 32'h0);
    access(32'h0800_0040, 1'b0);
    chk("R6 fallback after disable", {29'b0, hit_win}, 32'd5);
    clear_all();
  endtask

  task automatic t_fields();
    wr(14, 32'h0000_3000);
    wr(15, mk(31, 5, 17, 3, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1));
    access(32'h0000_3abc, 1'b1);
    chk("R3 slot", {31'b0, slot}, 32'h1);
    chk("R3 region io", {30'b0, region}, 32'd3);
    chk("R3 wide16", {31'b0, wide16}, 32'h1);
    chk("R8 setup", {28'b0, t_setup}, 32'd5);
    chk("R8 strobe", {27'b0, t_strobe}, 32'd17);
    chk("R8 hold", {28'b0, t_hold}, 32'd3);
    chk("R10 below limit", {31'b0, timing_over[7]}, 32'h0);
    wr(15, mk(31, 15, 31, 14, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
    chk("R10 sum 60 flagged", {31'b0, timing_over[7]}, 32'h1);
    wr(15, mk(31, 15, 30, 14, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1));
    chk("R10 sum 59 clear", {31'b0, timing_over[7]}, 32'h0);
    clear_all();
  endtask

  task automatic t_protect();
    wr(2, 32'h2000_0010);
    wr(3, mk(12, 1, 1, 1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1));
    access(32'h2000_00F0, 1'b0);
    chk("R7 unaligned base card address", card_addr, 32'h0000_00F0);
    chk("R9 protected read granted", {30'b0, grant, prot_err}, 32'b10);
    access(32'h2000_00F0, 1'b1);
    chk("R9 protected write blocked", {30'b0, grant, prot_err}, 32'b01);
    host_valid = 1'b0; #1;
    chk("R9 no pulse without access", {30'b0, grant, prot_err}, 32'b00);
    clear_all();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_sizes();
    t_priority();
    t_fields();
    t_protect();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule